// File: doc/BRIEF.md
# Dual Segment Counter Register

This block holds the segment-sequencing state for a 64-bit internal word that is reached over a 16-bit data bus. The word is split into four 16-bit quarters, called segments. The block keeps two independent counters: one for data writes and one for data reads. Each counter has a start limit, an end limit and a current value. The current value names the segment used by the next data cycle in that direction. After each data cycle in its own direction, a counter steps forward. When it reaches its end limit, it returns to its start limit.

Two copies of the whole register exist, a foreground copy and a background copy. A select input picks the active copy. Only the active copy can be loaded, read back, restarted or advanced. The inactive copy keeps its state until it is selected again.

The block does not hold the 64-bit storage or decode instructions. It outputs segment indices and a lane enable, and it receives register writes, a restart strobe and per-direction data-cycle strobes.

Top module: `seg_ctl_pair`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), both copies have start 0, end 3 and current 0 for both directions. Readback is therefore 16'h18C0, and `wr_seg` and `rd_seg` are 0.
- R2: Each cycle with `wr_cycle` high, and with no register write or restart, moves the write current value to the next segment. If the current value equals the write end limit, the next value is the write start limit. Otherwise it is the current value plus one.
- R3: The read counter follows the same rule on `rd_cycle`, independently of the write counter. Both may step in the same cycle.
- R4: A current value above the end limit counts up to 3, wraps to 0, and keeps counting up to the end limit. From the end limit it then jumps to the start limit.
- R5: A cycle with `reg_wr` high loads every field of the active copy from `reg_wdata` at once. The field positions are: [14:13] write start, [12:11] write end, [9:8] read start, [7:6] read end, [4:3] write current, [1:0] read current. A current value outside the start-to-end range is accepted.
- R6: `reg_rdata` shows the active copy in the R5 layout. Bits 15, 10, 5 and 2 always read as 0, whatever was written to them.
- R7: A data cycle in the same clock as a register write is ignored. The loaded values stand.
- R8: `seg_restart` returns both current values of the active copy to their start limits and leaves all limits unchanged. It takes priority over data cycles in the same clock. A register write in the same clock takes priority over it.
- R9: `bank_sel` = 0 selects the foreground copy and 1 selects the background copy. Loads, restarts and data cycles affect only the selected copy. The outputs show only the selected copy, and the other copy holds its state.
- R10: `wr_lane` is one-hot, with bit `wr_seg` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 1 | Active copy: 0 foreground, 1 background |
| reg_wr | input | 1 | Load the active copy from reg_wdata |
| reg_wdata | input | 16 | Register write value |
| seg_restart | input | 1 | Return the current values of the active copy to their start limits |
| wr_cycle | input | 1 | A data write cycle took place |
| rd_cycle | input | 1 | A data read cycle took place |
| reg_rdata | output | 16 | Readback of the active copy |
| wr_seg | output | 2 | Segment for the next data write |
| rd_seg | output | 2 | Segment for the next data read |
| wr_lane | output | 4 | One-hot enable for the write segment |

## Verification
The counters are first stepped from reset through their full default range, which shows plain increment and the wrap from 3 to 0. Directed loads then place the current value inside a narrow range, exactly on the end limit, and above the end limit. These cases separate the return-to-start rule from a plain modulo-4 wrap and from a clamp. Collision cases (a data cycle during a load, a restart with a data cycle, a load with a restart) confirm the priority order. A long random mix of all strobes, with bank switching, is compared against a behavioural model on every clock, so any leak of activity into the inactive copy shows up.

// File: rtl/seg_ctl_pkg.sv
// Package: shared widths, field positions and the step rule for the segment counters.
// Assumes a 16-bit register holding two counters of three SEG_W-bit fields each.
package seg_ctl_pkg;
    parameter int SEG_W   = 2;
    parameter int REG_W   = 16;
    localparam int N_SEG  = 1 << SEG_W;
    localparam int N_DIR  = 2;               // index 0: write direction, 1: read direction
    localparam int N_BANK = 2;               // index 0: foreground, 1: background

    // Field least-significant bit positions, indexed by direction.
    localparam int START_LSB [N_DIR] = '{13, 8};
    localparam int END_LSB   [N_DIR] = '{11, 6};
    localparam int CUR_LSB   [N_DIR] = '{3, 0};

    typedef logic [SEG_W-1:0] seg_t;

    // Next segment: return to start at the end limit, else count up with natural wrap.
    function automatic seg_t seg_next(input seg_t cur, input seg_t start_l, input seg_t end_l);
        seg_t inc;
        inc = seg_t'(cur + seg_t'(1));
        return (cur == end_l) ? start_l : inc;
    endfunction
endpackage

// File: rtl/seg_counter.sv
// Module: one segment counter (start limit, end limit, current value).
// What it does: loads all three fields on ld, returns current to start on restart,
// and steps current on step. Priority is ld over restart over step.
// Assumes synchronous active-low reset to start 0, end max, current 0.
module seg_counter
    import seg_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  seg_t ld_start,
    input  seg_t ld_end,
    input  seg_t ld_cur,
    input  logic restart,
    input  logic step,
    output seg_t start_q,
    output seg_t end_q,
    output seg_t cur_q
);
    localparam seg_t END_RST = seg_t'(N_SEG - 1);

    // Limits: reset defaults, replaced only by a register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= END_RST;
        end else if (ld) begin
            start_q <= ld_start;
            end_q   <= ld_end;
        end
    end

    // Current value: load, restart or step, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (ld)
            cur_q <= ld_cur;
        else if (restart)
            cur_q <= start_q;
        else if (step)
            cur_q <= seg_next(cur_q, start_q, end_q);
    end

    assert_load_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cur_q == $past(ld_cur)) && (start_q == $past(ld_start)) && (end_q == $past(ld_end)));

    assert_restart_to_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !ld) |=> (cur_q == $past(start_q)));

    assert_limits_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(start_q) && $stable(end_q)));

    // R2/R3: at the end limit a step lands on the start limit.
    assert_end_to_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !restart && (cur_q == end_q)) |=> (cur_q == $past(start_q)));

    // R4: away from the end limit a step always moves to the cyclic successor.
    assert_above_end_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !restart && (cur_q != end_q)) |=> (cur_q == seg_t'($past(cur_q) + seg_t'(1))));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld && !restart) |=> $stable(cur_q));
endmodule

// File: rtl/seg_bank.sv
// Module: one copy of the segment control register.
// What it does: splits a register write into fields for the write and read counters,
// and packs their state back into the readback layout with the reserved bits at zero.
// Assumes the caller gates every strobe with the bank select.
module seg_bank
    import seg_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [REG_W-1:0] wdata,
    input  logic             restart,
    input  logic             wr_step,
    input  logic             rd_step,
    output logic [REG_W-1:0] rdata,
    output seg_t             wr_cur,
    output seg_t             rd_cur
);
    seg_t start_v [N_DIR];
    seg_t end_v   [N_DIR];
    seg_t cur_v   [N_DIR];
    logic step_v  [N_DIR];

    // Per-direction step strobes.
    always_comb begin
        step_v[0] = wr_step;
        step_v[1] = rd_step;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        seg_counter u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld       (ld),
            .ld_start (wdata[START_LSB[d] +: SEG_W]),
            .ld_end   (wdata[END_LSB[d]   +: SEG_W]),
            .ld_cur   (wdata[CUR_LSB[d]   +: SEG_W]),
            .restart  (restart),
            .step     (step_v[d]),
            .start_q  (start_v[d]),
            .end_q    (end_v[d]),
            .cur_q    (cur_v[d])
        );
    end

    // Readback packing: reserved positions stay zero.
    always_comb begin
        rdata = '0;
        for (int d = 0; d < N_DIR; d++) begin
            rdata[START_LSB[d] +: SEG_W] = start_v[d];
            rdata[END_LSB[d]   +: SEG_W] = end_v[d];
            rdata[CUR_LSB[d]   +: SEG_W] = cur_v[d];
        end
    end

    // Current segments out.
    always_comb begin
        wr_cur = cur_v[0];
        rd_cur = cur_v[1];
    end

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[15] == 1'b0) && (rdata[10] == 1'b0) && (rdata[5] == 1'b0) && (rdata[2] == 1'b0));
endmodule

// File: rtl/seg_ctl_pair.sv
// Module: top of the dual segment counter register with foreground/background copies.
// What it does: routes register loads, restart and data-cycle strobes to the selected
// copy only, muxes its readback and segment indices out, and decodes the write lane.
// Assumes bank_sel is stable for the cycle it applies to; all outputs are from flops via muxes.
module seg_ctl_pair
    import seg_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             seg_restart,
    input  logic             wr_cycle,
    input  logic             rd_cycle,
    output logic [REG_W-1:0] reg_rdata,
    output logic [SEG_W-1:0] wr_seg,
    output logic [SEG_W-1:0] rd_seg,
    output logic [N_SEG-1:0] wr_lane
);
    logic [REG_W-1:0] rdata_b [N_BANK];
    seg_t             wr_b    [N_BANK];
    seg_t             rd_b    [N_BANK];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic hit;
        // Bank hit: strobes reach only the selected copy.
        always_comb hit = (bank_sel == b[0]);

        seg_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (hit && reg_wr),
            .wdata   (reg_wdata),
            .restart (hit && seg_restart),
            .wr_step (hit && wr_cycle),
            .rd_step (hit && rd_cycle),
            .rdata   (rdata_b[b]),
            .wr_cur  (wr_b[b]),
            .rd_cur  (rd_b[b])
        );
    end

    // Output mux for the selected copy.
    always_comb begin
        reg_rdata = rdata_b[bank_sel];
        wr_seg    = wr_b[bank_sel];
        rd_seg    = rd_b[bank_sel];
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_lane
        // Lane decode: one enable per segment.
        always_comb wr_lane[s] = (wr_seg == seg_t'(s));
    end

    assert_lane_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wr_lane));

    assert_bg_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_sel |=> $stable(rdata_b[1]));

    assert_fg_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |=> $stable(rdata_b[0]));

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rdata_b[0] == 16'h18C0) && (rdata_b[1] == 16'h18C0));
endmodule

// File: tb/test_seg_ctl_pair.sv
// Bench: a behavioural model of both copies is stepped alongside the design and compared every clock.
module test_seg_ctl_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        seg_restart = 1'b0;
    logic        wr_cycle = 1'b0;
    logic        rd_cycle = 1'b0;
    logic [15:0] reg_rdata;
    logic [1:0]  wr_seg;
    logic [1:0]  rd_seg;
    logic [3:0]  wr_lane;

    int n_run = 0;
    int n_fail = 0;

    // Model state: [bank][dir], dir 0 write, 1 read.
    int m_st [2][2];
    int m_en [2][2];
    int m_cu [2][2];

    always #2 clk = ~clk;

    seg_ctl_pair i_seg_ctl_pair (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .seg_restart(seg_restart), .wr_cycle(wr_cycle),
        .rd_cycle(rd_cycle), .reg_rdata(reg_rdata), .wr_seg(wr_seg),
        .rd_seg(rd_seg), .wr_lane(wr_lane)
    );

    function automatic logic [15:0] pack(int b);
        logic [15:0] v;
        v = '0;
        v[14:13] = 2'(m_st[b][0]); v[12:11] = 2'(m_en[b][0]);
        v[9:8]   = 2'(m_st[b][1]); v[7:6]   = 2'(m_en[b][1]);
        v[4:3]   = 2'(m_cu[b][0]); v[1:0]   = 2'(m_cu[b][1]);
        return v;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int d = 0; d < 2; d++) begin
                m_st[b][d] = 0; m_en[b][d] = 3; m_cu[b][d] = 0;
            end
    endtask

    task automatic model_clock(logic sel, logic ld, logic [15:0] wd, logic rs, logic ws, logic rds);
        int b;
        b = sel ? 1 : 0;
        if (ld) begin
            m_st[b][0] = wd[14:13]; m_en[b][0] = wd[12:11]; m_cu[b][0] = wd[4:3];
            m_st[b][1] = wd[9:8];   m_en[b][1] = wd[7:6];   m_cu[b][1] = wd[1:0];
        end else if (rs) begin
            m_cu[b][0] = m_st[b][0];
            m_cu[b][1] = m_st[b][1];
        end else begin
            if (ws) m_cu[b][0] = (m_cu[b][0] == m_en[b][0]) ? m_st[b][0] : (m_cu[b][0] + 1) % 4;
            if (rds) m_cu[b][1] = (m_cu[b][1] == m_en[b][1]) ? m_st[b][1] : (m_cu[b][1] + 1) % 4;
        end
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model for the selected copy.
    task automatic compare(string tag);
        int b;
        b = bank_sel ? 1 : 0;
        chk({tag, " wr_seg"}, 16'(wr_seg), 16'(m_cu[b][0]));
        chk({tag, " rd_seg"}, 16'(rd_seg), 16'(m_cu[b][1]));
        chk({tag, " readback R6"}, reg_rdata, pack(b));
        chk("R10 wr_lane", 16'(wr_lane), 16'(4'b0001 << m_cu[b][0]));
    endtask

    // One clock: drive after the falling edge, update model after the rising edge, compare at the next falling edge.
    task automatic cyc(string tag, logic sel, logic ld, logic [15:0] wd, logic rs, logic ws, logic rds);
        bank_sel = sel; reg_wr = ld; reg_wdata = wd; seg_restart = rs; wr_cycle = ws; rd_cycle = rds;
        @(posedge clk);
        #1;
        model_clock(sel, ld, wd, rs, ws, rds);
        @(negedge clk);
        reg_wr = 1'b0; seg_restart = 1'b0; wr_cycle = 1'b0; rd_cycle = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of both copies
        compare("R1 fg");
        chk("R1 value", reg_rdata, 16'h18C0);
        cyc("R1 bg", 1'b1, 0, '0, 0, 0, 0);
        chk("R1 bg value", reg_rdata, 16'h18C0);

        // R2: default write range 0..3 then back to 0
        for (int i = 0; i < 5; i++) cyc("R2 default", 1'b0, 0, '0, 0, 1, 0);
        // R3: read counter alone, then both together
        for (int i = 0; i < 3; i++) cyc("R3 read", 1'b0, 0, '0, 0, 0, 1);
        for (int i = 0; i < 4; i++) cyc("R3 both", 1'b0, 0, '0, 0, 1, 1);

        // R5/R6: write start1 end2 cur1, read start2 end3 cur0; reserved bits set
        cyc("R5 load", 1'b0, 1, 16'h8000 | (16'd1 << 13) | (16'd2 << 11) | 16'h0400
            | (16'd2 << 8) | (16'd3 << 6) | 16'h0020 | (16'd1 << 3) | 16'h0004, 0, 0, 0);
        chk("R6 zeros", reg_rdata & 16'h8424, 16'h0000);
        for (int i = 0; i < 4; i++) cyc("R2 narrow", 1'b0, 0, '0, 0, 1, 1);

        // R4: write start 1 end 1 current 2: expect 3,0,1,1
        cyc("R4 load", 1'b0, 1, (16'd1 << 13) | (16'd1 << 11) | (16'd2 << 3) | (16'd3 << 6), 0, 0, 0);
        cyc("R4 step", 1'b0, 0, '0, 0, 1, 0); chk("R4 to 3", 16'(wr_seg), 16'd3);
        cyc("R4 step", 1'b0, 0, '0, 0, 1, 0); chk("R4 wrap 0", 16'(wr_seg), 16'd0);
        cyc("R4 step", 1'b0, 0, '0, 0, 1, 0); chk("R4 end", 16'(wr_seg), 16'd1);
        cyc("R4 step", 1'b0, 0, '0, 0, 1, 0); chk("R4 start", 16'(wr_seg), 16'd1);

        // R7: data cycles with a load are ignored
        cyc("R7 load+cycle", 1'b0, 1, (16'd3 << 11) | (16'd2 << 3) | (16'd3 << 6) | 16'd1, 0, 1, 1);
        chk("R7 wr kept", 16'(wr_seg), 16'd2);
        chk("R7 rd kept", 16'(rd_seg), 16'd1);

        // R8: restart beats data cycles; load beats restart
        cyc("R8 restart+cycle", 1'b0, 0, '0, 1, 1, 1);
        chk("R8 wr at start", 16'(wr_seg), 16'd0);
        cyc("R8 load+restart", 1'b0, 1, (16'd2 << 13) | (16'd3 << 11) | (16'd3 << 3) | (16'd3 << 6), 1, 0, 0);
        chk("R8 load wins", 16'(wr_seg), 16'd3);

        // R9: background activity leaves foreground unchanged
        cyc("R9 bg load", 1'b1, 1, 16'h7FFF, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R9 bg step", 1'b1, 0, '0, 0, 1, 1);
        cyc("R9 fg view", 1'b0, 0, '0, 0, 0, 0);
        chk("R9 fg wr", 16'(wr_seg), 16'd3);

        // Random mix over both copies
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc("R2 R3 R9 random", 1'($urandom_range(0, 1)), r < 8, 16'($urandom),
                (r >= 8) && (r < 14), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule